// File: doc/BRIEF.md
# PCI Bus Target Transaction Engine

This block is a 32-bit target on a shared PCI bus. It watches the multiplexed address/data lines, the command/byte-enable nibble and the active-low cycle-frame signal. On the first clock where frame goes low it captures the address and command. If the command is a memory or I/O access that lands inside its small register bank, it claims the transaction with device-select. It then completes one or more data phases, reading from or writing into the bank.

Writes use the active-low byte enables of each data phase to pick the lanes that are stored. Reads are driven onto the bus through an output enable, which turns on only after a one-clock turnaround. Memory bursts step through consecutive words of the bank. A separate local read port lets the surrounding logic see any word of the bank.

Top module: `pci_tgt_engine`

## Requirements
- R1: While reset is high and after it, with no transaction, devsel_n and trdy_n read 1 and devsel_oe, trdy_oe and ad_oe read 0.
- R2: Commands 0110, 1100 and 1110 (memory reads) and 0111 and 1111 (memory writes) are claimed when address bits [31:6] equal the memory window base. devsel_n goes low on the clock edge that samples the address phase.
- R3: Commands 0010 (I/O read) and 0011 (I/O write) are claimed when byte address bits [31:6] equal the I/O window base.
- R4: Every other command, including 1101 (two-phase 64-bit address) and configuration commands, and any address outside both windows, is never claimed. devsel_oe stays 0 and the bank is unchanged.
- R5: A memory address is a word address: bits [1:0] are ignored and bits [5:2] pick the word. A memory burst advances one word per completed beat and wraps inside the bank. An I/O address is a byte address whose word bits [5:2] select the word, and an I/O burst stays on that word.
- R6: On a write beat, byte-enable bit k low stores ad_in[8k+7:8k], and bit k high leaves that byte unchanged.
- R7: A beat completes only on an edge where irdy_n and trdy_n are both low. Clocks with irdy_n high move neither the data nor the word pointer.
- R8: On the clock after the address edge, trdy_n rises to 1 and is driven while ad_oe stays 0 (turnaround). On the next edge trdy_n goes low, and for reads ad_oe goes high with the first word on ad_out.
- R9: A beat taken with frame_n high is the last. On that edge devsel_n and trdy_n go to 1 while still driven and ad_oe goes 0. One clock later devsel_oe and trdy_oe go to 0.
- R10: loc_rdata shows the bank word selected by loc_idx, one clock after loc_idx is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Cycle frame, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| cbe_n | input | 4 | Command (address phase) / byte enables, active low (data phase) |
| ad_in | input | 32 | Address/data sampled from the bus |
| ad_out | output | 32 | Read data to the bus |
| ad_oe | output | 1 | Tri-state enable for ad_out |
| devsel_n | output | 1 | Device select, active low |
| devsel_oe | output | 1 | Tri-state enable for devsel_n |
| trdy_n | output | 1 | Target ready, active low |
| trdy_oe | output | 1 | Tri-state enable for trdy_n |
| loc_idx | input | 4 | Local port word index |
| loc_rdata | output | 32 | Local port read data |

## Verification
The hardest case to reach from the ports is a transaction that must not be claimed while the bus still looks busy. One example is a two-phase 64-bit address, where frame stays low into a second address-like clock. Another is an out-of-window write whose low address bits alias a live bank word. The bench drives the second address phase and then real data beats with irdy_n low. It checks that device-select never turns on, and reads the aliased word back through the local port. Burst wrap from the top word is also exercised, together with initiator wait states inside a read burst.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_TURN,
    ST_DATA,
    ST_END
  } tgt_state_e;

  localparam logic [3:0] CMD_IO_RD  = 4'b0010;
  localparam logic [3:0] CMD_IO_WR  = 4'b0011;
  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
  localparam logic [3:0] CMD_MRD_MUL = 4'b1100;
  localparam logic [3:0] CMD_MRD_LN = 4'b1110;
  localparam logic [3:0] CMD_MWR_INV = 4'b1111;

  typedef struct packed {
    logic valid;
    logic wr;
    logic io;
  } cmd_info_t;

  function automatic cmd_info_t classify_cmd(input logic [3:0] cmd);
    cmd_info_t ci;
    ci = '0;
    unique case (cmd)
      CMD_IO_RD:   ci = '{valid: 1'b1, wr: 1'b0, io: 1'b1};
      CMD_IO_WR:   ci = '{valid: 1'b1, wr: 1'b1, io: 1'b1};
      CMD_MEM_RD,
      CMD_MRD_MUL,
      CMD_MRD_LN:  ci = '{valid: 1'b1, wr: 1'b0, io: 1'b0};
      CMD_MEM_WR,
      CMD_MWR_INV: ci = '{valid: 1'b1, wr: 1'b1, io: 1'b0};
      default:     ci = '0;
    endcase
    return ci;
  endfunction

endpackage

// File: rtl/pci_tgt_decode.sv
module pci_tgt_decode
  import pci_tgt_pkg::*;
#(
  parameter int          IDX_W    = 4,
  parameter logic [31:0] MEM_BASE = 32'h8000_0000,
  parameter logic [31:0] IO_BASE  = 32'h0000_1000
) (
  input  logic [31:2]      addr,
  input  logic [3:0]       cmd,
  output logic             hit,
  output logic             is_wr,
  output logic             is_io,
  output logic [IDX_W-1:0] idx
);
  localparam int HI = IDX_W + 2;

  cmd_info_t ci;
  logic      mem_win;
  logic      io_win;

  always_comb begin
    ci      = classify_cmd(cmd);
    mem_win = (addr[31:HI] == MEM_BASE[31:HI]);
    io_win  = (addr[31:HI] == IO_BASE[31:HI]);
    hit     = ci.valid && (ci.io ? io_win : mem_win);
    is_wr   = ci.wr;
    is_io   = ci.io;
    idx     = addr[HI-1:2];
  end
endmodule

// File: rtl/pci_tgt_regbank.sv
module pci_tgt_regbank #(
  parameter int WORDS = 16,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] widx,
  input  logic [31:0]   wdata,
  input  logic [3:0]    wstrb,
  input  logic [AW-1:0] ridx,
  output logic [31:0]   rdata,
  input  logic [AW-1:0] lidx,
  output logic [31:0]   ldata
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int l = 0; l < 4; l++) begin
        if (wstrb[l]) mem[widx][8*l +: 8] <= wdata[8*l +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    rdata <= mem[ridx];
    ldata <= mem[lidx];
  end
endmodule

// File: rtl/pci_tgt_engine.sv
module pci_tgt_engine
  import pci_tgt_pkg::*;
#(
  parameter int          NUM_WORDS = 16,
  parameter logic [31:0] MEM_BASE  = 32'h8000_0000,
  parameter logic [31:0] IO_BASE   = 32'h0000_1000,
  localparam int         IDX_W     = $clog2(NUM_WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic [3:0]       cbe_n,
  input  logic [31:0]      ad_in,
  output logic [31:0]      ad_out,
  output logic             ad_oe,
  output logic             devsel_n,
  output logic             devsel_oe,
  output logic             trdy_n,
  output logic             trdy_oe,
  input  logic [IDX_W-1:0] loc_idx,
  output logic [31:0]      loc_rdata
);
  tgt_state_e       state;
  logic             frame_q;
  logic             wr_q;
  logic             io_q;
  logic [IDX_W-1:0] idx_q;

  logic             dec_hit;
  logic             dec_wr;
  logic             dec_io;
  logic [IDX_W-1:0] dec_idx;

  logic             addr_phase;
  logic             beat;
  logic [IDX_W-1:0] next_idx;
  logic [IDX_W-1:0] rd_idx;

  pci_tgt_decode #(
    .IDX_W   (IDX_W),
    .MEM_BASE(MEM_BASE),
    .IO_BASE (IO_BASE)
  ) u_dec (
    .addr (ad_in[31:2]),
    .cmd  (cbe_n),
    .hit  (dec_hit),
    .is_wr(dec_wr),
    .is_io(dec_io),
    .idx  (dec_idx)
  );

  always_comb begin
    addr_phase = (state == ST_IDLE) && !frame_n && frame_q;
    beat       = (state == ST_DATA) && !irdy_n && !trdy_n;
    next_idx   = io_q ? idx_q : idx_q + IDX_W'(1);
    if (state == ST_IDLE)  rd_idx = dec_idx;
    else if (beat)         rd_idx = next_idx;
    else                   rd_idx = idx_q;
  end

  pci_tgt_regbank #(
    .WORDS(NUM_WORDS)
  ) u_bank (
    .clk  (clk),
    .we   (beat && wr_q),
    .widx (idx_q),
    .wdata(ad_in),
    .wstrb(~cbe_n),
    .ridx (rd_idx),
    .rdata(ad_out),
    .lidx (loc_idx),
    .ldata(loc_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      frame_q   <= 1'b1;
      wr_q      <= 1'b0;
      io_q      <= 1'b0;
      idx_q     <= '0;
      devsel_n  <= 1'b1;
      devsel_oe <= 1'b0;
      trdy_n    <= 1'b1;
      trdy_oe   <= 1'b0;
      ad_oe     <= 1'b0;
    end else begin
      frame_q <= frame_n;
      unique case (state)
        ST_IDLE: begin
          if (addr_phase && dec_hit) begin
            state     <= ST_TURN;
            wr_q      <= dec_wr;
            io_q      <= dec_io;
            idx_q     <= dec_idx;
            devsel_n  <= 1'b0;
            devsel_oe <= 1'b1;
            trdy_n    <= 1'b1;
            trdy_oe   <= 1'b1;
          end
        end
        ST_TURN: begin
          state  <= ST_DATA;
          trdy_n <= 1'b0;
          ad_oe  <= !wr_q;
        end
        ST_DATA: begin
          if (beat) begin
            idx_q <= next_idx;
            if (frame_n) begin
              state    <= ST_END;
              devsel_n <= 1'b1;
              trdy_n   <= 1'b1;
              ad_oe    <= 1'b0;
            end
          end
        end
        ST_END: begin
          state     <= ST_IDLE;
          devsel_oe <= 1'b0;
          trdy_oe   <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pci_tgt_engine_chk.sv
module pci_tgt_engine_chk (
  input logic       clk,
  input logic       rst,
  input logic       frame_n,
  input logic [3:0] cbe_n,
  input logic       devsel_n,
  input logic       devsel_oe,
  input logic       trdy_n,
  input logic       ad_oe
);
  logic frame_prev;

  always_ff @(posedge clk) begin
    if (rst) frame_prev <= 1'b1;
    else     frame_prev <= frame_n;
  end

  // R8: target-ready low only inside a claimed transaction
  a_r8_trdy_in_claim: assert property (@(posedge clk) disable iff (rst)
    !trdy_n |-> !devsel_n);

  // R8: read enable comes on only after device-select was already low
  a_r8_turnaround: assert property (@(posedge clk) disable iff (rst)
    $rose(ad_oe) |-> $past(!devsel_n) && !trdy_n);

  // R9: device-select released high while still driven, enable off next clock
  a_r9_release: assert property (@(posedge clk) disable iff (rst)
    $rose(devsel_n) |-> devsel_oe ##1 !devsel_oe);

  // R4: a two-phase address command is never claimed
  a_r4_dual_addr: assert property (@(posedge clk) disable iff (rst)
    (!frame_n && frame_prev && cbe_n == 4'b1101 && !devsel_oe) |=> !devsel_oe);

  // R9: data is driven only with device-select driven low
  a_r9_ad_claimed: assert property (@(posedge clk) disable iff (rst)
    ad_oe |-> devsel_oe && !devsel_n);
endmodule

bind pci_tgt_engine pci_tgt_engine_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .frame_n  (frame_n),
  .cbe_n    (cbe_n),
  .devsel_n (devsel_n),
  .devsel_oe(devsel_oe),
  .trdy_n   (trdy_n),
  .ad_oe    (ad_oe)
);

// File: tb/pci_tgt_engine_tb.sv
module pci_tgt_engine_tb;
  localparam int          NW    = 16;
  localparam logic [31:0] MBASE = 32'h8000_0000;
  localparam logic [31:0] IBASE = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_n = 1'b1;
  logic        irdy_n = 1'b1;
  logic [3:0]  cbe_n = 4'hF;
  logic [31:0] ad_in = '0;
  logic [31:0] ad_out;
  logic        ad_oe, devsel_n, devsel_oe, trdy_n, trdy_oe;
  logic [3:0]  loc_idx = '0;
  logic [31:0] loc_rdata;

  int tests = 0;
  int fails = 0;
  logic [31:0] ref_mem [NW];
  logic [31:0] exp_q [$];

  always #2 clk = ~clk;

  pci_tgt_engine #(.NUM_WORDS(NW), .MEM_BASE(MBASE), .IO_BASE(IBASE)) u_dut (
    .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .cbe_n(cbe_n),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .devsel_n(devsel_n),
    .devsel_oe(devsel_oe), .trdy_n(trdy_n), .trdy_oe(trdy_oe),
    .loc_idx(loc_idx), .loc_rdata(loc_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor: pops an expected read word on every completed read beat
  always @(negedge clk) begin
    #1;
    if (!rst && ad_oe && !trdy_n && !irdy_n) begin
      if (exp_q.size() == 0) chk(1'b0, "R7 unexpected read beat", ad_out, 32'h0);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(ad_out === e, "R5 read beat data", ad_out, e);
      end
    end
  end

  task automatic txn(input logic [3:0] cmd, input logic [31:0] addr, input int n,
                     input bit wr, input bit io, input logic [3:0] be,
                     input logic [31:0] seed, input int stall_beat);
    int idx;
    idx = int'(addr[5:2]);
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr; cbe_n = cmd;
    @(negedge clk);
    chk(devsel_n == 1'b0 && devsel_oe == 1'b1, "R2/R3 claim devsel", {31'b0, devsel_n}, 32'h0);
    chk(trdy_n == 1'b1 && trdy_oe == 1'b1 && ad_oe == 1'b0, "R8 turnaround clock",
        {29'b0, trdy_n, trdy_oe, ad_oe}, 32'h6);
    for (int b = 0; b < n; b++) begin
      logic [31:0] d;
      d = seed + 32'h0101_0101 * b;
      ad_in = wr ? d : 32'hDEAD_BEEF;
      cbe_n = be;
      frame_n = (b == n - 1);
      irdy_n = 1'b0;
      if (!wr) exp_q.push_back(ref_mem[idx]);
      else
        for (int k = 0; k < 4; k++) if (!be[k]) ref_mem[idx][8*k +: 8] = d[8*k +: 8];
      if (b == stall_beat) begin
        irdy_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        irdy_n = 1'b0;
      end
      @(negedge clk);
      if (b == 0)
        chk(trdy_n == 1'b0 && ad_oe == !wr, "R8 first data clock",
            {30'b0, trdy_n, ad_oe}, {30'b0, 1'b0, !wr});
      if (b == 0) @(negedge clk);
      if (!io) idx = (idx + 1) % NW;
    end
    frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF;
    chk(devsel_n && devsel_oe && trdy_n && trdy_oe && !ad_oe, "R9 release clock",
        {27'b0, devsel_n, devsel_oe, trdy_n, trdy_oe, ad_oe}, 32'h1E);
    @(negedge clk);
    chk(!devsel_oe && !trdy_oe, "R9 enables off", {30'b0, devsel_oe, trdy_oe}, 32'h0);
  endtask

  task automatic no_claim(input logic [3:0] cmd, input logic [31:0] addr,
                          input bit dual, input string req);
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr; cbe_n = cmd;
    if (dual) begin
      @(negedge clk);
      ad_in = MBASE; cbe_n = 4'b0111;
    end
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      frame_n = (c == 3); irdy_n = 1'b0; ad_in = 32'hA5A5_A5A5; cbe_n = 4'h0;
      chk(!devsel_oe && devsel_n && !trdy_oe, req, {31'b0, devsel_oe}, 32'h0);
    end
    @(negedge clk);
    frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF;
    chk(!devsel_oe, req, {31'b0, devsel_oe}, 32'h0);
  endtask

  task automatic loc_chk(input int i, input string req);
    loc_idx = i[3:0];
    @(negedge clk);
    chk(loc_rdata === ref_mem[i], req, loc_rdata, ref_mem[i]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(devsel_n && trdy_n && !devsel_oe && !trdy_oe && !ad_oe, "R1 during reset",
        {27'b0, devsel_n, trdy_n, devsel_oe, trdy_oe, ad_oe}, 32'h18);
    rst = 1'b0;
    @(negedge clk);
    chk(devsel_n && trdy_n && !devsel_oe && !trdy_oe && !ad_oe, "R1 after reset",
        {27'b0, devsel_n, trdy_n, devsel_oe, trdy_oe, ad_oe}, 32'h18);

    // R2 R6: fill the bank with a memory write burst, all lanes
    txn(4'b0111, MBASE, NW, 1'b1, 1'b0, 4'h0, 32'h1000_0000, -1);
    // R10: local port
    loc_chk(0, "R10 local word 0");
    loc_chk(7, "R10 local word 7");
    loc_chk(15, "R10 local word 15");

    // R7 R8: memory read burst with initiator wait states
    txn(4'b0110, MBASE + 32'h8, 4, 1'b0, 1'b0, 4'h0, 32'h0, 2);
    // R2: read multiple, read line, write-and-invalidate wrapping at top (R5)
    txn(4'b1100, MBASE + 32'h28, 2, 1'b0, 1'b0, 4'h0, 32'h0, -1);
    txn(4'b1110, MBASE + 32'h3C, 1, 1'b0, 1'b0, 4'h0, 32'h0, -1);
    txn(4'b1111, MBASE + 32'h3C, 3, 1'b1, 1'b0, 4'h0, 32'h7700_0000, 1);
    loc_chk(15, "R5 wrap word 15");
    loc_chk(0, "R5 wrap word 0");
    loc_chk(1, "R5 wrap word 1");
    txn(4'b0110, MBASE + 32'h3C, 3, 1'b0, 1'b0, 4'h0, 32'h0, -1);

    // R6 R5: partial lanes, low address bits ignored for memory
    txn(4'b0111, MBASE + 32'hE, 1, 1'b1, 1'b0, 4'b1010, 32'hCAFE_F00D, -1);
    loc_chk(3, "R6 byte lanes word 3");
    txn(4'b0111, MBASE + 32'h11, 2, 1'b1, 1'b0, 4'b0101, 32'h1234_5678, -1);
    loc_chk(4, "R6 byte lanes word 4");
    loc_chk(5, "R6 byte lanes word 5");

    // R3 R5: I/O byte address, burst stays on one word
    txn(4'b0011, IBASE + 32'h15, 2, 1'b1, 1'b1, 4'h0, 32'h5555_0000, -1);
    loc_chk(5, "R5 io word 5");
    loc_chk(6, "R5 io word 6 untouched");
    txn(4'b0010, IBASE + 32'h17, 2, 1'b0, 1'b1, 4'h0, 32'h0, -1);

    // R4: commands and addresses that must not be claimed
    no_claim(4'b1101, MBASE + 32'hC, 1'b1, "R4 dual address");
    no_claim(4'b1010, MBASE, 1'b0, "R4 config read");
    no_claim(4'b0001, MBASE, 1'b0, "R4 special cycle");
    no_claim(4'b0111, 32'h9000_000C, 1'b0, "R4 memory miss");
    no_claim(4'b0011, MBASE + 32'hC, 1'b0, "R4 io miss");
    no_claim(4'b0110, IBASE, 1'b0, "R4 mem cmd at io window");
    loc_chk(3, "R4 bank unchanged");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all read beats seen", exp_q.size(), 32'h0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule